// File: doc/BRIEF.md
# Frame Alignment Evaluator

This block measures how far a frame evaluation strobe trails the local frame reference edge. The result is a count of half master-clock periods. A measurement is started through a start bit. The block then reports an offset value and a completion flag, which software polls. The bus timing convention arrives on `gci_mode`. With `gci_mode` low, falling edges are compared. With `gci_mode` high, rising edges are compared.

Software first holds the start bit low for a whole frame, then raises it. The block opens a one-frame capture window at the next frame reference edge. It latches the first strobe edge seen in that window. It raises the completion flag at the reference edge that follows. The flag and the value stay in place until software clears the start bit. Every input is sampled on the rising clock edge. The strobe is also sampled on the falling clock edge, and this second sample resolves the half period.

Top module: `frame_align_eval`

## Requirements
- R1: After reset, `eval_done` is 0 and `offset` is 0.
- R2: A rising `start_eval` is accepted only if `start_eval` was low across at least two frame reference edges, which is one full frame. Otherwise the rise is ignored: `eval_done` stays 0 and `offset` keeps its value.
- R3: After an accepted rise, `eval_done` goes to 1 right after the second frame reference edge that follows, and not before.
- R4: While `start_eval` stays high, `eval_done` stays 1 and `offset` does not change. When `start_eval` goes low, `eval_done` reads 0 after the next rising clock edge, and `offset` keeps its value.
- R5: With `gci_mode` = 0, the reference edge is a falling edge of `frame_pulse` and the measured edge is a falling edge of `eval_strobe`.
- R6: With `gci_mode` = 1, the reference edge is a rising edge of `frame_pulse` and the measured edge is a rising edge of `eval_strobe`.
- R7: `offset` is the number of half clock periods from the reference edge to the strobe edge. Bits [12:1] hold whole clock periods. Bit 0 is 1 when the strobe edge falls in the first half of a clock period, which the falling-clock sample detects.
- R8: `offset` ranges from 0 to 2*FRAME_CLKS-1. A strobe edge half a period before the reference edge reads 2*FRAME_CLKS-1.
- R9: `offset` is set to 0 when a start is accepted. It then takes the first strobe edge found from the first reference edge after the start, up to but not including the second.
- R10: A measurement after completion needs `start_eval` cleared for one full frame again, and then yields a fresh result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_pulse | input | 1 | Local frame pulse that defines the reference edge |
| eval_strobe | input | 1 | Frame evaluation strobe to be measured |
| gci_mode | input | 1 | 0: compare falling edges, 1: compare rising edges |
| start_eval | input | 1 | Start bit; the rise starts a measurement, low clears the result flag |
| offset | output | OFS_W (13) | Measured offset in half clock periods |
| eval_done | output | 1 | Measurement complete |

## Verification
The strobe is placed at even offsets, landing just after a falling clock edge, and at odd offsets, landing just after a rising clock edge. Comparing the two shows whether the falling-clock sample sets bit 0 correctly. Each mode is tried with strobe and frame pulses of its own polarity, so a measurement that uses the wrong edge gives a different value. Offsets of 0, 2*FRAME_CLKS-2 and 2*FRAME_CLKS-1 test the wrap at the frame boundary. Two starts that are ignored, one after a short low period and one after a low period that spans only a single reference edge, separate the full-frame arming rule from plain edge detection.

// File: rtl/frame_align_eval.sv
module frame_align_eval #(
  parameter int FRAME_CLKS = 4096,
  parameter int OFS_W      = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_pulse,
  input  logic             eval_strobe,
  input  logic             gci_mode,
  input  logic             start_eval,
  output logic [OFS_W-1:0] offset,
  output logic             eval_done
);

  localparam int CW = $clog2(FRAME_CLKS);
  localparam logic [CW-1:0] LAST = CW'(FRAME_CLKS - 1);

  typedef enum logic [1:0] {IDLE, RUN, DONE} st_t;

  st_t              st;
  logic             fp_q, sp_q, sn_q, start_q, runf, got;
  logic [1:0]       lowf;
  logic [CW-1:0]    cnt_q;
  logic [OFS_W-1:0] ofs_q;

  // normalise polarity: active edge is always 0 -> 1
  wire fp_n = frame_pulse ^ ~gci_mode;
  wire st_n = eval_strobe ^ ~gci_mode;

  wire fedge    = fp_n & ~fp_q;
  wire half_hit = ~sp_q & sn_q;
  wire full_hit = ~sn_q & st_n;
  wire s_hit    = half_hit | full_hit;

  wire [CW-1:0] cur  = fedge ? '0 : cnt_q;
  wire [CW-1:0] prev = (cur == '0) ? LAST : cur - 1'b1;
  wire [CW-1:0] whole = half_hit ? prev : cur;
  wire [OFS_W-1:0] meas = {(OFS_W-1)'(whole), half_hit};

  wire win = fedge ? ~runf : runf;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) sn_q <= 1'b0;
    else        sn_q <= st_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fp_q    <= 1'b0;
      sp_q    <= 1'b0;
      start_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      fp_q    <= fp_n;
      sp_q    <= st_n;
      start_q <= start_eval;
      cnt_q   <= fedge ? CW'(1) : (cnt_q == LAST ? '0 : cnt_q + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      lowf      <= '0;
      runf      <= 1'b0;
      got       <= 1'b0;
      ofs_q     <= '0;
      eval_done <= 1'b0;
    end else if (!start_eval) begin
      st        <= IDLE;
      eval_done <= 1'b0;
      if (fedge && lowf != 2'd2) lowf <= lowf + 1'b1;
    end else begin
      lowf <= '0;
      case (st)
        IDLE: if (!start_q && lowf == 2'd2) begin
          st    <= RUN;
          runf  <= 1'b0;
          got   <= 1'b0;
          ofs_q <= '0;
        end
        RUN: begin
          if (win && s_hit && !got) begin
            ofs_q <= meas;
            got   <= 1'b1;
          end
          if (fedge) begin
            if (!runf) runf <= 1'b1;
            else begin
              st        <= DONE;
              eval_done <= 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign offset = ofs_q;

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !start_eval |=> !eval_done);

  p_done_on_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eval_done) |-> $past(fedge));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_done && start_eval) |=> $stable(offset));

  p_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    offset[OFS_W-1:1] <= (OFS_W-1)'(LAST));

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RUN && $past(st) == IDLE) |-> $past(lowf) == 2'd2);

endmodule

// File: tb/frame_align_eval_test.sv
module frame_align_eval_test;
  localparam int F = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_pulse = 1'b1;
  logic eval_strobe = 1'b1;
  logic gci_mode = 1'b0;
  logic start_eval = 1'b0;
  logic [12:0] offset;
  logic eval_done;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int h_v = 0;
  bit gci_v = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  frame_align_eval #(.FRAME_CLKS(F), .OFS_W(13)) uut (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
    .eval_strobe(eval_strobe), .gci_mode(gci_mode),
    .start_eval(start_eval), .offset(offset), .eval_done(eval_done));

  function automatic logic act(bit x);
    return gci_v ? x : !x;
  endfunction

  // reference edge sampled at posedges with cyc % F == 1
  initial forever begin
    @(posedge clk);
    #1;
    gci_mode = gci_v;
    frame_pulse = act((cyc % F) == 0);
    if (h_v % 2) eval_strobe = act((cyc % F) == ((h_v / 2) + 1) % F);
    #4;
    if (!(h_v % 2)) eval_strobe = act((cyc % F) == (h_v / 2) % F);
  end

  task automatic check(string req, int act_v, int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act_v, exp_v, cyc);
    end
  endtask

  task automatic goto(int n);
    forever begin
      @(posedge clk);
      #2;
      if (cyc >= n) break;
    end
  endtask

  function automatic int next_phase(int from, int ph);
    int c = from;
    while ((c % F) != ph) c++;
    return c;
  endfunction

  task automatic measure(bit g, int h, string req);
    int c;
    start_eval = 1'b0;
    gci_v = g;
    h_v = h;
    c = next_phase(cyc + 3 * F, 5);
    goto(c);
    start_eval = 1'b1;
    goto(c + 2);
    check("R9 offset cleared at start", offset, 0);
    goto(c + 2 * F - 5);
    check("R3 done low before second edge", eval_done, 0);
    goto(c + 2 * F - 4);
    check("R3 done high after second edge", eval_done, 1);
    check(req, offset, h);
    goto(c + 3 * F);
    check("R4 done held", eval_done, 1);
    check("R4 offset held", offset, h);
    start_eval = 1'b0;
    goto(c + 3 * F + 1);
    check("R4 done cleared", eval_done, 0);
    check("R4 offset kept after clear", offset, h);
  endtask

  task automatic ignored_starts(int prev_h);
    int c;
    c = next_phase(cyc, 10);
    goto(c);
    start_eval = 1'b1;
    goto(c + 3 * F);
    check("R2 short low ignored done", eval_done, 0);
    check("R2 short low ignored offset", offset, prev_h);
    c = next_phase(cyc, 20);
    goto(c);
    start_eval = 1'b0;
    c = next_phase(cyc + 1, 10);
    goto(c);
    start_eval = 1'b1;
    goto(c + 3 * F);
    check("R2 one-edge low ignored done", eval_done, 0);
    check("R2 one-edge low ignored offset", offset, prev_h);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 done after reset", eval_done, 0);
    check("R1 offset after reset", offset, 0);
    rst_n = 1'b1;
    measure(1'b0, 10, "R5 falling-edge even offset");
    measure(1'b0, 7, "R7 half-period offset");
    measure(1'b1, 0, "R6 rising-edge zero offset");
    measure(1'b1, 2 * F - 1, "R8 wrap to top half-step");
    ignored_starts(2 * F - 1);
    measure(1'b0, 2 * F - 2, "R10 re-armed measurement");
    finish_run();
  end
endmodule